// File: doc/BRIEF.md
# SWD host transaction engine

This block is the host end of a two-wire serial debug link. A caller gives it one register access: a port select (debug port or access port), a read/write flag, the two upper address bits of a word-aligned register, and a 32-bit write word. It then runs the whole exchange on the wire. First it sends the 8-bit request packet. It turns the data line around, takes in the 3-bit acknowledge from the target and turns the line around again. If the target accepted, it moves the 32-bit data word and its parity bit in the right direction. At the end it reports the captured read word, the raw acknowledge and a 2-bit status. A batch of accesses is run by starting them one after another and waiting for `done` each time.

The serial clock comes from a programmable divider. Each half period of SWCLK lasts `active divider + 1` system clocks, and SWCLK stays low while the engine is idle. A new divider value that makes the link slower takes effect at once, even while a transfer is running. A value that makes the link faster is held in a pending register and only copied in once the engine is idle. As a result, the transfer that is running never speeds up.

The controller is a single state machine:

- `S_IDLE` goes to `S_REQ` when `start` is sampled.
- `S_REQ` moves through 8 bit periods and then goes to `S_TRN1`.
- `S_TRN1` goes to `S_ACK`.
- `S_ACK` moves through 3 bit periods and then goes to `S_TRN2`.
- `S_TRN2` goes to `S_WDATA` for an accepted write, to `S_RDATA` for an accepted read, or to `S_DONE` for any other acknowledge.
- `S_WDATA` moves through 33 bit periods and then goes to `S_DONE`.
- `S_RDATA` moves through 33 bit periods and then goes to `S_TRN3`.
- `S_TRN3` goes to `S_DONE`.
- `S_DONE` goes back to `S_IDLE` after one cycle.

Each bit period ends on a falling SWCLK event, and every state change away from idle or done happens there.

Top module: `swd_host_engine`

## Requirements
- R1: The request goes out least significant bit first as 8 bit periods: bit0 start = 1, bit1 port select (1 = access port), bit2 read flag (1 = read), bit3 address bit A2 = `req_addr[0]`, bit4 address bit A3 = `req_addr[1]`, bit6 stop = 0, bit7 park = 1.
- R2: Request bit5 is a parity bit chosen so that bits 1 to 5 hold an even number of ones.
- R3: After the park bit come one turnaround period, three acknowledge periods and a second turnaround period. `swdio_oe` is 0 in every turnaround period and in every period the target drives. `swdio_oe` is 1 in every request and write-data period.
- R4: The acknowledge is sampled least significant bit first and shown on `ack_raw`. Code 3'b001 gives status 0 (OK), 3'b010 gives 1 (WAIT) and 3'b100 gives 2 (FAULT). Any other code gives 3 (protocol error). For any code other than OK, no data phase follows.
- R5: For an accepted write, 32 data bits and then one even-parity bit are driven LSB first, starting in the period right after the second turnaround. Status ends at 0.
- R6: For an accepted read, 32 data bits and one parity bit are sampled LSB first, followed by one turnaround. `rdata` takes the 32 bits. Status is 0 when the 33 bits hold an even number of ones, and 3 otherwise.
- R7: Each SWCLK half period is `div_active + 1` system clocks. `done` is high for exactly one cycle, 2·N·(`div_active`+1) clock edges after the edge that samples `start`. N is 46 for an accepted write, 47 for an accepted read and 13 when there is no data phase. `busy` is high in between.
- R8: A `div_wr` value that is greater than or equal to `div_active` appears on `div_active` after the next edge, even during a transfer. A smaller value leaves `div_active` unchanged while `busy` is high. It is copied on the first edge at which the engine is idle, which is the second edge after the write when the write happens while idle.
- R9: After reset, `busy`, `done`, `swclk` and `swdio_oe` are 0 and `div_active` equals the `DIV_RESET` parameter. While idle, `swclk` and `swdio_oe` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an access; sampled only while idle |
| req_ap | input | 1 | 1 selects the access port, 0 the debug port |
| req_rd | input | 1 | 1 for a read, 0 for a write |
| req_addr | input | 2 | Register address bits A3:A2 |
| req_wdata | input | DATA_W | Word to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 WAIT, 2 FAULT, 3 protocol or parity error |
| ack_raw | output | 3 | Acknowledge as sampled |
| rdata | output | DATA_W | Word captured by the last read |
| div_wr | input | 1 | Write strobe for the clock divider |
| div_val | input | DIV_W | New divider value |
| div_active | output | DIV_W | Divider currently in use |
| swclk | output | 1 | Serial clock to the target |
| swdio_o | output | 1 | Data line value when driven |
| swdio_oe | output | 1 | Data line drive enable |
| swdio_i | input | 1 | Data line value from the pad |

## Verification
All results land at one known edge. Status, `ack_raw` and `rdata` settle on the edge that raises `done`, and that edge comes exactly 2·N·(divider+1) edges after the start edge, so the bench records the cycle count of the start edge and of `done`. It reads every result on the falling clock half that follows. The bench's target model changes `swdio_i` right after each falling SWCLK edge and captures `swdio_o`/`swdio_oe` on each rising SWCLK edge, which puts every bit in the middle of its sampling window. Divider effects are checked on the port one edge after an immediate write, and two edges after `done` for a deferred write.

// File: rtl/swdh_pkg.sv
package swdh_pkg;

    localparam int REQ_W = 8;
    localparam int ACK_W = 3;

    localparam logic [ACK_W-1:0] ACK_OK    = 3'b001;
    localparam logic [ACK_W-1:0] ACK_WAIT  = 3'b010;
    localparam logic [ACK_W-1:0] ACK_FAULT = 3'b100;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_WAIT  = 2'd1,
        ST_FAULT = 2'd2,
        ST_PROTO = 2'd3
    } swdh_status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REQ,
        S_TRN1,
        S_ACK,
        S_TRN2,
        S_WDATA,
        S_RDATA,
        S_TRN3,
        S_DONE
    } swdh_state_e;

    // Request byte, LSB is the first bit on the wire.
    function automatic logic [REQ_W-1:0] build_req(input logic ap, input logic rd,
                                                   input logic [1:0] a);
        logic par;
        par = ap ^ rd ^ a[0] ^ a[1];
        build_req = {1'b1, 1'b0, par, a[1], a[0], rd, ap, 1'b1};
    endfunction

    function automatic swdh_status_e decode_ack(input logic [ACK_W-1:0] ack);
        swdh_status_e s;
        unique case (ack)
            ACK_OK:    s = ST_OK;
            ACK_WAIT:  s = ST_WAIT;
            ACK_FAULT: s = ST_FAULT;
            default:   s = ST_PROTO;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/swdh_divreg.sv
module swdh_divreg #(
    parameter int          DIV_W     = 16,
    parameter int unsigned DIV_RESET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    output logic [DIV_W-1:0] div_active
);

    localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(DIV_RESET);

    logic [DIV_W-1:0] pend_q;
    logic [DIV_W-1:0] act_q;

    // Slower (larger) values apply at once; faster ones wait for idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= RST_VAL;
            act_q  <= RST_VAL;
        end else if (div_wr) begin
            pend_q <= div_val;
            if (div_val >= act_q) begin
                act_q <= div_val;
            end
        end else if (idle) begin
            act_q <= pend_q;
        end
    end

    assign div_active = act_q;

endmodule

// File: rtl/swdh_clkgen.sv
module swdh_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             swclk,
    output logic             rise_ev,
    output logic             fall_ev
);

    logic [DIV_W-1:0] cnt_q;
    logic             clk_q;
    logic             hit;

    assign hit     = run && (cnt_q >= div);
    assign rise_ev = hit && !clk_q;
    assign fall_ev = hit && clk_q;
    assign swclk   = clk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
        end else if (hit) begin
            cnt_q <= '0;
            clk_q <= ~clk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
    import swdh_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          DIV_W     = 16,
    parameter int unsigned DIV_RESET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_ap,
    input  logic              req_rd,
    input  logic [1:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [ACK_W-1:0]  ack_raw,
    output logic [DATA_W-1:0] rdata,
    input  logic              div_wr,
    input  logic [DIV_W-1:0]  div_val,
    output logic [DIV_W-1:0]  div_active,
    output logic              swclk,
    output logic              swdio_o,
    output logic              swdio_oe,
    input  logic              swdio_i
);

    localparam int               CNT_W    = $clog2(DATA_W + 1);
    localparam int               SH_W     = DATA_W + 1;
    localparam logic [CNT_W-1:0] LAST_REQ = CNT_W'(REQ_W - 1);
    localparam logic [CNT_W-1:0] LAST_ACK = CNT_W'(ACK_W - 1);
    localparam logic [CNT_W-1:0] LAST_DAT = CNT_W'(DATA_W);

    swdh_state_e       state_q, state_d;
    logic [CNT_W-1:0]  bit_q;
    logic [SH_W-1:0]   tx_q;
    logic [SH_W-1:0]   rx_q;
    logic [ACK_W-1:0]  ack_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              rd_q;
    swdh_status_e      status_q;
    logic              rise_ev, fall_ev;
    logic              run;

    swdh_divreg #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) div_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .idle       (!busy),
        .div_wr     (div_wr),
        .div_val    (div_val),
        .div_active (div_active)
    );

    swdh_clkgen #(.DIV_W(DIV_W)) clk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div     (div_active),
        .swclk   (swclk),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    // Next state: every bit period ends on a falling SWCLK event.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_REQ;
            S_REQ:   if (fall_ev && bit_q == LAST_REQ) state_d = S_TRN1;
            S_TRN1:  if (fall_ev) state_d = S_ACK;
            S_ACK:   if (fall_ev && bit_q == LAST_ACK) state_d = S_TRN2;
            S_TRN2: begin
                if (fall_ev) begin
                    if (ack_q != ACK_OK) state_d = S_DONE;
                    else if (rd_q)       state_d = S_RDATA;
                    else                 state_d = S_WDATA;
                end
            end
            S_WDATA: if (fall_ev && bit_q == LAST_DAT) state_d = S_DONE;
            S_RDATA: if (fall_ev && bit_q == LAST_DAT) state_d = S_TRN3;
            S_TRN3:  if (fall_ev) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Shift registers, bit counter and results.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q    <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            ack_q    <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            rd_q     <= 1'b0;
            status_q <= ST_OK;
        end else if (state_q == S_IDLE) begin
            if (start) begin
                tx_q    <= {{(SH_W - REQ_W){1'b0}}, build_req(req_ap, req_rd, req_addr)};
                wdata_q <= req_wdata;
                rd_q    <= req_rd;
                ack_q   <= '0;
                bit_q   <= '0;
            end
        end else begin
            if (rise_ev) begin
                if (state_q == S_ACK)   ack_q <= {swdio_i, ack_q[ACK_W-1:1]};
                if (state_q == S_RDATA) rx_q  <= {swdio_i, rx_q[SH_W-1:1]};
            end
            if (fall_ev) begin
                bit_q <= (state_d != state_q) ? '0 : bit_q + 1'b1;
                if (state_q == S_REQ || state_q == S_WDATA) tx_q <= tx_q >> 1;
                if (state_q == S_TRN2) begin
                    tx_q <= {^wdata_q, wdata_q};
                    if (ack_q != ACK_OK) status_q <= decode_ack(ack_q);
                end
                if (state_q == S_WDATA && state_d == S_DONE) status_q <= ST_OK;
                if (state_q == S_TRN3) begin
                    rdata_q  <= rx_q[DATA_W-1:0];
                    status_q <= (^rx_q) ? ST_PROTO : ST_OK;
                end
            end
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        swdio_oe = 1'b0;
        unique case (state_q)
            S_IDLE:          busy = 1'b0;
            S_DONE: begin
                busy = 1'b0;
                done = 1'b1;
            end
            S_REQ, S_WDATA:  swdio_oe = 1'b1;
            default:         swdio_oe = 1'b0;
        endcase
        swdio_o = swdio_oe & tx_q[0];
        run     = busy;
    end

    assign status  = status_q;
    assign ack_raw = ack_q;
    assign rdata   = rdata_q;

endmodule

// File: rtl/swdh_checker.sv
module swdh_checker #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             swclk,
    input logic             swdio_o,
    input logic             swdio_oe,
    input logic [DIV_W-1:0] div_active
);

    a_r1_start_bit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (swdio_oe && swdio_o));

    a_r3_oe_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(swdio_oe)) |-> $fell(swclk));

    a_r5_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$stable(swdio_o)) |-> $fell(swclk));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r8_no_speedup_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (div_active >= $past(div_active)));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!swclk && !swdio_oe));

endmodule

bind swd_host_engine swdh_checker #(.DIV_W(DIV_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .swclk      (swclk),
    .swdio_o    (swdio_o),
    .swdio_oe   (swdio_oe),
    .div_active (div_active)
);

// File: tb/swd_host_engine_tb.sv
module swd_host_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        req_ap = 1'b0;
    logic        req_rd = 1'b0;
    logic [1:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        div_wr = 1'b0;
    logic [15:0] div_val = '0;
    logic        swdio_i = 1'b0;
    logic        busy, done, swclk, swdio_o, swdio_oe;
    logic [1:0]  status;
    logic [2:0]  ack_raw;
    logic [31:0] rdata;
    logic [15:0] div_active;

    int unsigned cyc = 0;
    int unsigned t_done = 0;
    bit          done_flag = 1'b0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    swd_host_engine dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_ap     (req_ap),
        .req_rd     (req_rd),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .busy       (busy),
        .done       (done),
        .status     (status),
        .ack_raw    (ack_raw),
        .rdata      (rdata),
        .div_wr     (div_wr),
        .div_val    (div_val),
        .div_active (div_active),
        .swclk      (swclk),
        .swdio_o    (swdio_o),
        .swdio_oe   (swdio_oe),
        .swdio_i    (swdio_i)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (done) begin
            t_done    = cyc;
            done_flag = 1'b1;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic set_div(input logic [15:0] v);
        @(negedge clk);
        div_wr  = 1'b1;
        div_val = v;
        @(negedge clk);
        div_wr  = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [1:0] exp_status(input logic [2:0] ack);
        if (ack == 3'b001) return 2'd0;
        if (ack == 3'b010) return 2'd1;
        if (ack == 3'b100) return 2'd2;
        return 2'd3;
    endfunction

    task automatic run_xfer(input logic ap, input logic rd, input logic [1:0] a,
                            input logic [31:0] wd, input logic [2:0] ack,
                            input logic [31:0] tword, input logic bad_par,
                            input int dv, input bit timing);
        logic [7:0]  req;
        logic [7:0]  exp_req;
        logic [32:0] cap;
        logic [32:0] word;
        int          oe_bad;
        int unsigned t0;
        int          n;
        oe_bad = 0;
        cap    = '0;
        word   = {(^tword) ^ bad_par, tword};
        @(negedge clk);
        req_ap    = ap;
        req_rd    = rd;
        req_addr  = a;
        req_wdata = wd;
        done_flag = 1'b0;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0    = cyc;
        for (int i = 0; i < 8; i++) begin
            @(posedge swclk);
            req[i] = swdio_o;
            if (swdio_oe !== 1'b1) oe_bad++;
        end
        @(negedge swclk);
        @(posedge swclk);
        if (swdio_oe !== 1'b0) oe_bad++;
        @(negedge swclk);
        for (int i = 0; i < 3; i++) begin
            swdio_i = ack[i];
            @(posedge swclk);
            if (swdio_oe !== 1'b0) oe_bad++;
            @(negedge swclk);
        end
        swdio_i = 1'b0;
        @(posedge swclk);
        if (swdio_oe !== 1'b0) oe_bad++;
        @(negedge swclk);
        if (ack == 3'b001) begin
            for (int i = 0; i < 33; i++) begin
                if (rd) swdio_i = word[i];
                @(posedge swclk);
                if (rd) begin
                    if (swdio_oe !== 1'b0) oe_bad++;
                end else begin
                    cap[i] = swdio_o;
                    if (swdio_oe !== 1'b1) oe_bad++;
                end
                @(negedge swclk);
            end
            swdio_i = 1'b0;
            if (rd) begin
                @(posedge swclk);
                if (swdio_oe !== 1'b0) oe_bad++;
                @(negedge swclk);
            end
        end
        wait (done_flag);
        @(negedge clk);
        exp_req = {1'b1, 1'b0, ap ^ rd ^ a[0] ^ a[1], a[1], a[0], rd, ap, 1'b1};
        chk("R1 request framing and fields", 64'(req & 8'hDF), 64'(exp_req & 8'hDF));
        chk("R2 request parity bit", 64'(req[5]), 64'(exp_req[5]));
        chk("R3 drive enable per period", 64'(oe_bad), 64'd0);
        chk("R4 raw acknowledge", 64'(ack_raw), 64'(ack));
        if (ack == 3'b001 && rd)
            chk("R6 read status", 64'(status), bad_par ? 64'd3 : 64'd0);
        else
            chk("R4 status from acknowledge", 64'(status), 64'(exp_status(ack)));
        if (ack == 3'b001 && !rd)
            chk("R5 write data and parity", 64'(cap), 64'({^wd, wd}));
        if (ack == 3'b001 && rd)
            chk("R6 read data", 64'(rdata), 64'(tword));
        if (timing) begin
            n = (ack != 3'b001) ? 13 : (rd ? 47 : 46);
            chk("R7 done edge", 64'(t_done - t0), 64'(2 * n * (dv + 1)));
        end
        chk("R7 busy after done", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset busy", 64'(busy), 64'd0);
        chk("R9 reset done", 64'(done), 64'd0);
        chk("R9 reset swclk", 64'(swclk), 64'd0);
        chk("R9 reset oe", 64'(swdio_oe), 64'd0);
        chk("R9 reset divider", 64'(div_active), 64'd4);

        // Faster value while idle: copied on the second edge.
        set_div(16'd0);
        chk("R8 idle speedup applied", 64'(div_active), 64'd0);
        repeat (5) @(negedge clk);
        chk("R9 idle swclk quiet", 64'(swclk), 64'd0);

        // All request encodings, accepted, fastest clock.
        for (int k = 0; k < 16; k++) begin
            logic [31:0] w;
            w = 32'h9E37_79B9 * (k + 1);
            run_xfer(k[0], k[1], k[3:2], w, 3'b001, w ^ 32'hFFFF_0000, 1'b0, 0, 1'b1);
        end

        // Every acknowledge code, both directions.
        set_div(16'd1);
        for (int c = 0; c < 8; c++) begin
            for (int r = 0; r < 2; r++) begin
                run_xfer(1'b1, r[0], 2'(c), 32'h0F0F_3C3C + 32'(c), 3'(c),
                         32'hC001_D00D ^ 32'(c), 1'b0, 1, 1'b1);
            end
        end

        // Read with a wrong parity bit.
        set_div(16'd2);
        run_xfer(1'b0, 1'b1, 2'd3, 32'h0, 3'b001, 32'h1234_5678, 1'b1, 2, 1'b1);
        run_xfer(1'b0, 1'b1, 2'd1, 32'h0, 3'b001, 32'h0000_0000, 1'b1, 2, 1'b1);

        // Divider changes while a transfer runs.
        set_div(16'd3);
        chk("R8 slowdown applied", 64'(div_active), 64'd3);
        fork
            run_xfer(1'b1, 1'b0, 2'd2, 32'hDEAD_BEEF, 3'b001, 32'h0, 1'b0, 3, 1'b1);
            begin
                repeat (30) @(negedge clk);
                div_wr  = 1'b1;
                div_val = 16'd1;
                @(negedge clk);
                div_wr  = 1'b0;
                repeat (3) @(negedge clk);
                chk("R8 speedup deferred while busy", 64'(div_active), 64'd3);
            end
        join
        @(negedge clk);
        chk("R8 speedup taken at idle", 64'(div_active), 64'd1);
        fork
            run_xfer(1'b0, 1'b1, 2'd0, 32'h0, 3'b001, 32'h8000_0001, 1'b0, 1, 1'b0);
            begin
                repeat (30) @(negedge clk);
                div_wr  = 1'b1;
                div_val = 16'd5;
                @(negedge clk);
                div_wr  = 1'b0;
                chk("R8 slowdown busy state", 64'(busy), 64'd1);
                chk("R8 slowdown immediate while busy", 64'(div_active), 64'd5);
            end
        join

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule